// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a processor's memory port and judges every access it makes, whether an instruction fetch or a data transfer, against eight programmable address windows and a default background window. Each access enters on a valid/ready stream carrying its address, its privilege level, its direction and a flag for fault-handler context. One cycle later the block returns a verdict: permitted or faulting, and the number of the window whose permissions decided it. Fetches and data accesses travel the same path and are checked in the same way.

Software sets the block up through a small word-addressed register file. It holds an identification word, a control word, a window selector, and a base word and a limit word that are reached indirectly through the selector. Windows have a granularity of 32 bytes and may overlap. When they overlap, the highest-numbered window decides. The low interrupt-vector area and the system control space are always permitted while checking is active, so that a bad setup cannot lock the processor out of its own control registers.

Back-pressure on the response stream: `acc_ready` is high when no verdict is pending, or when the pending verdict is being taken in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the verdict and the window number stay unchanged and no new access is accepted.

Top module: `mpc_top`

## Requirements
- R1: After reset the control word, selector, every base word and every limit word read as zero, `rsp_valid` is low, and the identification word (offset 0x00) reads the window count, 8, in bits [15:8].
- R2: Registers sit at byte offsets 0x00 identification, 0x04 control, 0x08 selector, 0x0C base, 0x10 limit. The selector keeps bits [2:0] and ignores higher bits. Base and limit reads and writes act on the window the selector names. Base keeps bits [31:5] as the address and bits [2:0] as permissions. Limit keeps bits [31:5] as the address and bit 0 as the window enable. All other bits read zero.
- R3: While control bit 0 (enable) is clear, every access is permitted and reports window number 8.
- R4: A window matches when its enable bit is set and the access address A satisfies base ≤ A[31:5] ≤ limit, using the stored bits [31:5], with both ends included. A disabled window never matches.
- R5: When several enabled windows match, the one with the highest number decides and its number is reported.
- R6: Base bit 2 set allows unprivileged access. When it is clear, an unprivileged access to the window faults and a privileged one does not.
- R7: Base bit 1 set makes the window read-only: a write faults and a read does not.
- R8: Base bit 0 set denies every access to the window, privileged or not.
- R9: When enabled and no window matches, a privileged access is permitted if control bit 2 is set and faults otherwise. An unprivileged unmatched access always faults. Both report window number 8.
- R10: While enabled, addresses below 0x400 (vector area) and in 0xE000E000 to 0xE000EFFF (system control space) are permitted with window number 8, whatever the window settings.
- R11: When `acc_handler` is high and control bit 1 is clear, the access is permitted with window number 8.
- R12: A verdict appears on `rsp_valid`/`rsp_fault`/`rsp_region` in the cycle after its access is accepted. While `rsp_valid` is high and `rsp_ready` is low, the verdict holds steady and `acc_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Register access strobe |
| cfg_wr | input | 1 | Register write when high, read when low |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| acc_valid | input | 1 | Access to check is present |
| acc_ready | output | 1 | Checker can take the access |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_handler | input | 1 | Access is made from fault-handler context |
| rsp_valid | output | 1 | Verdict is present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_fault | output | 1 | Access faults |
| rsp_region | output | 4 | Deciding window number, 8 when none decided |

## Verification
Register reads are combinational, so the bench checks them a fraction of a cycle after it presents the offset. It checks register writes at the next negative edge after the write edge. A verdict is registered once, so the bench presents each access at a negative edge and samples the verdict at the following negative edge, one rising edge later. The back-pressure sequence samples at each negative edge while `rsp_ready` is low to confirm the held verdict. It then samples the queued access's verdict one edge after `rsp_ready` returns high.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int ADDR_W = 32;
  localparam int GRAN_LSB = 5;
  localparam int PAGE_W = ADDR_W - GRAN_LSB;

  localparam logic [2:0] OFS_ID   = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd1;
  localparam logic [2:0] OFS_SEL  = 3'd2;
  localparam logic [2:0] OFS_BASE = 3'd3;
  localparam logic [2:0] OFS_LIM  = 3'd4;

  typedef struct packed {
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] limit;
    logic              en;
    logic              unpriv_ok;
    logic              ro;
    logic              deny;
  } win_cfg_t;

  typedef struct packed {
    logic bg_priv;
    logic in_handler;
    logic on;
  } ctrl_t;
endpackage

// File: rtl/mpc_regs.sv
module mpc_regs
  import mpc_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_sel,
  input  logic                   cfg_wr,
  input  logic [4:0]             cfg_addr,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output logic [ADDR_W-1:0]      cfg_rdata,
  output ctrl_t                  ctrl,
  output win_cfg_t [NREG-1:0]    wins
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IDX_W-1:0] sel_q;
  ctrl_t            ctrl_q;
  win_cfg_t [NREG-1:0] wins_q;
  logic [2:0]       word;
  logic             do_wr;
  win_cfg_t         cur;

  assign word  = cfg_addr[4:2];
  assign do_wr = cfg_sel && cfg_wr;
  assign cur   = wins_q[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ctrl_q <= '0;
      wins_q <= '0;
    end else if (do_wr) begin
      unique case (word)
        OFS_CTRL: ctrl_q <= ctrl_t'(cfg_wdata[2:0]);
        OFS_SEL:  sel_q  <= cfg_wdata[IDX_W-1:0];
        OFS_BASE: begin
          wins_q[sel_q].base      <= cfg_wdata[ADDR_W-1:GRAN_LSB];
          wins_q[sel_q].unpriv_ok <= cfg_wdata[2];
          wins_q[sel_q].ro        <= cfg_wdata[1];
          wins_q[sel_q].deny      <= cfg_wdata[0];
        end
        OFS_LIM: begin
          wins_q[sel_q].limit <= cfg_wdata[ADDR_W-1:GRAN_LSB];
          wins_q[sel_q].en    <= cfg_wdata[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (word)
      OFS_ID:   cfg_rdata[15:8] = 8'(NREG);
      OFS_CTRL: cfg_rdata[2:0] = ctrl_q;
      OFS_SEL:  cfg_rdata[IDX_W-1:0] = sel_q;
      OFS_BASE: cfg_rdata = {cur.base, 2'b00, cur.unpriv_ok, cur.ro, cur.deny};
      OFS_LIM:  cfg_rdata = {cur.limit, {(GRAN_LSB-1){1'b0}}, cur.en};
      default:  cfg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign wins = wins_q;
endmodule

// File: rtl/mpc_match.sv
module mpc_match
  import mpc_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  win_cfg_t [NREG-1:0] wins,
  output logic [NREG-1:0]     hit
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:GRAN_LSB];

  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic above_base;
    logic below_lim;
    assign above_base = page >= wins[g].base;
    assign below_lim  = page <= wins[g].limit;
    assign hit[g]     = wins[g].en && above_base && below_lim;
  end
endmodule

// File: rtl/mpc_prio.sv
module mpc_prio
  import mpc_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]     hit,
  input  win_cfg_t [NREG-1:0] wins,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output win_cfg_t            win
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign win = wins[idx];
endmodule

// File: rtl/mpc_top.sv
module mpc_top
  import mpc_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [31:0] VEC_SIZE = 32'h0000_0400,
  parameter logic [31:0] SCS_BASE = 32'hE000_E000,
  parameter logic [31:0] SCS_SIZE = 32'h0000_1000,
  localparam int RW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          cfg_wr,
  input  logic [4:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [31:0]   acc_addr,
  input  logic          acc_priv,
  input  logic          acc_write,
  input  logic          acc_handler,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [RW-1:0] rsp_region
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [RW-1:0] NO_WIN = RW'(NREG);

  ctrl_t               ctrl;
  win_cfg_t [NREG-1:0] wins;
  logic [NREG-1:0]     hit;
  logic                found;
  logic [IDX_W-1:0]    idx;
  win_cfg_t            win;
  logic                ctrl_on;
  logic                ctrl_hf;
  logic                in_vec;
  logic                in_scs;
  logic                active;
  logic                nxt_fault;
  logic [RW-1:0]       nxt_region;

  mpc_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctrl(ctrl), .wins(wins)
  );

  mpc_match #(.NREG(NREG)) u_match (.addr(acc_addr), .wins(wins), .hit(hit));

  mpc_prio #(.NREG(NREG)) u_prio (
    .hit(hit), .wins(wins), .found(found), .idx(idx), .win(win)
  );

  assign ctrl_on = ctrl.on;
  assign ctrl_hf = ctrl.in_handler;
  assign in_vec  = acc_addr < VEC_SIZE;
  assign in_scs  = (acc_addr >= SCS_BASE) && ((acc_addr - SCS_BASE) < SCS_SIZE);
  assign active  = ctrl_on && !(acc_handler && !ctrl_hf) && !in_vec && !in_scs;

  always_comb begin
    nxt_fault  = 1'b0;
    nxt_region = NO_WIN;
    if (active) begin
      if (found) begin
        nxt_region = RW'(idx);
        nxt_fault  = win.deny || (!acc_priv && !win.unpriv_ok) || (acc_write && win.ro);
      end else begin
        nxt_fault  = !(acc_priv && ctrl.bg_priv);
      end
    end
  end

  assign acc_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_region <= NO_WIN;
    end else if (acc_ready) begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_fault  <= nxt_fault;
        rsp_region <= nxt_region;
      end
    end
  end
endmodule

// File: rtl/mpc_top_checker.sv
module mpc_top_checker #(
  parameter int NREG = 8,
  parameter logic [31:0] VEC_SIZE = 32'h0000_0400,
  localparam int RW = $clog2(NREG + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic [31:0]   acc_addr,
  input logic          acc_handler,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_fault,
  input logic [RW-1:0] rsp_region,
  input logic          ctrl_on,
  input logic          ctrl_hf
);
  logic took;
  assign took = acc_valid && acc_ready;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rsp_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_region));

  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid);

  a_r3_off_permits: assert property (@(posedge clk) disable iff (!rst_n)
    took && !ctrl_on |=> !rsp_fault && (rsp_region == RW'(NREG)));

  a_r10_vector_ok: assert property (@(posedge clk) disable iff (!rst_n)
    took && (acc_addr < VEC_SIZE) |=> !rsp_fault);

  a_r11_handler_ok: assert property (@(posedge clk) disable iff (!rst_n)
    took && acc_handler && !ctrl_hf |=> !rsp_fault);
endmodule

bind mpc_top mpc_top_checker #(.NREG(NREG), .VEC_SIZE(VEC_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_addr(acc_addr), .acc_handler(acc_handler), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_region(rsp_region),
  .ctrl_on(ctrl_on), .ctrl_hf(ctrl_hf)
);

// File: tb/mpc_top_bench.sv
`timescale 1ns/1ps
module mpc_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 0, cfg_wr = 0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic acc_valid = 0, acc_ready;
  logic [31:0] acc_addr = '0;
  logic acc_priv = 0, acc_write = 0, acc_handler = 0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_fault;
  logic [3:0] rsp_region;

  int errors = 0, checks = 0;
  logic [31:0] mb [8];
  logic [31:0] ml [8];
  logic [2:0]  mctrl = '0;

  always #2.5 clk = ~clk;

  mpc_top u_mpc_top (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic wr_reg(input logic [4:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_wr = 1; cfg_addr = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 0; cfg_wr = 0;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] ofs, input logic [31:0] exp);
    cfg_sel = 1; cfg_wr = 0; cfg_addr = ofs;
    #0.5;
    check(tag, cfg_rdata, exp);
    cfg_sel = 0;
  endtask

  task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] l);
    wr_reg(5'h08, 32'(i));
    wr_reg(5'h0C, b);
    wr_reg(5'h10, l);
    mb[i] = b & 32'hFFFF_FFE7;
    ml[i] = l & 32'hFFFF_FFE1;
  endtask

  task automatic set_ctrl(input logic [2:0] c);
    wr_reg(5'h04, {29'b0, c});
    mctrl = c;
  endtask

  // Expected verdict computed from the requirements
  function automatic void model(input logic [31:0] a, input logic pr, input logic wr,
                                input logic hd, output logic f, output logic [3:0] rg,
                                output string tag);
    int win = -1, nhit = 0;
    f = 0; rg = 4'd8;
    if (!mctrl[0]) begin tag = "R3"; return; end
    if (hd && !mctrl[1]) begin tag = "R11"; return; end
    if (a < 32'h400 || (a >= 32'hE000E000 && a < 32'hE000F000)) begin tag = "R10"; return; end
    for (int i = 0; i < 8; i++)
      if (ml[i][0] && a[31:5] >= mb[i][31:5] && a[31:5] <= ml[i][31:5]) begin
        win = i; nhit++;
      end
    if (win < 0) begin
      f = !(pr && mctrl[2]); tag = "R9"; return;
    end
    rg = 4'(win);
    tag = (nhit > 1) ? "R5" : "R4";
    if (mb[win][0]) begin f = 1; tag = "R8"; end
    else if (!pr && !mb[win][2]) begin f = 1; tag = "R6"; end
    else if (wr && mb[win][1]) begin f = 1; tag = "R7"; end
    else if (!pr || wr) tag = wr ? "R7" : "R6";
  endfunction

  task automatic access(input logic [31:0] a, input logic pr, input logic wr, input logic hd);
    logic f; logic [3:0] rg; string tag;
    @(negedge clk);
    acc_addr = a; acc_priv = pr; acc_write = wr; acc_handler = hd; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    model(a, pr, wr, hd, f, rg, tag);
    check({"R12 valid ", tag}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, f});
    check({tag, " region"}, {28'b0, rsp_region}, {28'b0, rg});
  endtask

  task automatic sweep();
    logic [31:0] a [6];
    for (int r = 0; r < 8; r++) begin
      a[0] = {mb[r][31:5], 5'b0} - 32'd4;
      a[1] = {mb[r][31:5], 5'b0};
      a[2] = {mb[r][31:5], 5'b0} + 32'h1F4;
      a[3] = {ml[r][31:5], 5'b0} + 32'h1F;
      a[4] = {ml[r][31:5], 5'b0} + 32'h20;
      a[5] = {ml[r][31:5], 5'b0} + 32'h10;
      for (int k = 0; k < 6; k++)
        for (int c = 0; c < 4; c++)
          for (int h = 0; h < 2; h++)
            access(a[k], c[0], c[1], h[0]);
    end
    for (int c = 0; c < 4; c++) begin
      access(32'h0000_0000, c[0], c[1], 0);
      access(32'h0000_03FC, c[0], c[1], 0);
      access(32'hE000_E010, c[0], c[1], 0);
      access(32'hE000_F000, c[0], c[1], 0);
      access(32'h8000_0000, c[0], c[1], 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mb[i] = '0; ml[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rd_check("R1 id", 5'h00, 32'h0000_0800);
    rd_check("R1 ctrl", 5'h04, 32'h0);
    rd_check("R1 sel", 5'h08, 32'h0);
    rd_check("R1 base", 5'h0C, 32'h0);
    rd_check("R1 limit", 5'h10, 32'h0);
    rst_n = 1;
    // Windows 0..6 overlap pairwise; window 7 covers 0..0x7FF and denies all
    for (int i = 0; i < 7; i++) begin
      logic [31:0] b;
      b = 32'h1000_0000 + 32'(i) * 32'h400;
      set_win(i, b | ((32'(i) & 3) << 1) | (i == 5 ? 32'h1 : 32'h0),
                 (b + 32'h5E0) | 32'h1E | (i == 3 ? 32'h0 : 32'h1));
    end
    set_win(7, 32'h0000_0007 | 32'h18, 32'h0000_07E1);
    // R2: indirect readback, masking of unused bits
    for (int i = 0; i < 8; i++) begin
      wr_reg(5'h08, 32'(i) | 32'hF0);
      rd_check("R2 sel mask", 5'h08, 32'(i));
      rd_check("R2 base", 5'h0C, mb[i]);
      rd_check("R2 limit", 5'h10, ml[i]);
    end
    rd_check("R2 id offset", 5'h00, 32'h0000_0800);
    // R3 disabled, then R4..R11 under each control setting
    set_ctrl(3'b000); sweep();
    set_ctrl(3'b001); sweep();
    set_ctrl(3'b101); sweep();
    set_ctrl(3'b011); sweep();
    set_ctrl(3'b111); sweep();
    rd_check("R2 ctrl", 5'h04, 32'h7);
    // R12: back-pressure
    set_ctrl(3'b001);
    @(negedge clk);
    rsp_ready = 0;
    acc_addr = 32'h1000_0000; acc_priv = 0; acc_write = 1; acc_handler = 0; acc_valid = 1;
    @(negedge clk);
    check("R12 first valid", {31'b0, rsp_valid}, 32'd1);
    check("R12 first fault", {31'b0, rsp_fault}, 32'd1);
    check("R12 first region", {28'b0, rsp_region}, 32'd0);
    check("R12 ready low", {31'b0, acc_ready}, 32'd0);
    acc_addr = 32'h1000_0400; acc_priv = 1; acc_write = 0;
    repeat (3) begin
      @(negedge clk);
      check("R12 held fault", {31'b0, rsp_fault}, 32'd1);
      check("R12 held region", {28'b0, rsp_region}, 32'd0);
      check("R12 held ready", {31'b0, acc_ready}, 32'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    acc_valid = 0;
    check("R12 second valid", {31'b0, rsp_valid}, 32'd1);
    check("R12 second fault", {31'b0, rsp_fault}, 32'd0);
    check("R12 second region", {28'b0, rsp_region}, 32'd1);
    @(negedge clk);
    check("R12 drained", {31'b0, rsp_valid}, 32'd0);
    finish_run();
  end
endmodule